// File: doc/BRIEF.md
# Mailbox Chunk Transfer Sequencer

This block stages a binary image into a device through a small register mailbox, one chunk per transaction, with no software involved. It is the master on a 32-bit register bus. For each transaction it writes a request object (a size header, a load command header and one chunk of image dwords) into the device's write-data register. It then starts the device through the control register and polls the status register until the device reports ready. Finally it reads a four-dword response back through the read-data register.

The response tells the sequencer where the next chunk begins. The device chooses that position, so chunks need not follow each other in address order. The image itself sits outside the block: the sequencer presents a byte offset and a dword index on a source port and takes the dword back in the same cycle. Every response is checked against the expected header, the image length and an error flag. A run ends with a done flag or with one of six error codes, and that result holds until the next start pulse.

Top module: `mbox_stage_seq`

## Requirements
- R1: Each transaction writes, all to address 0x8, in this order: header low dword, header high dword, command low dword 3, command high dword 0, then CHUNK_DW chunk dwords. Chunk dword k is `src_data` taken while `src_offset` shows the chunk's byte offset and `src_index` equals k.
- R2: The request header low dword has OWNER_ID in bits 15:0, 0x0B in bits 23:16 and zero above. The high dword equals 4 + CHUNK_DW, which is the object size in dwords.
- R3: After the last chunk dword, exactly one write of 0x8000_0000 to address 0x0 starts the device.
- R4: After the start write, the block waits POLL_CYCLES cycles before each read of status (address 0x4). It stops polling at the first status with bit 31 set, or after POLL_LIMIT reads.
- R5: When polling stops and the last status has bit 2 set, the run ends with code 1 (io). When no status showed bit 31, the run ends with code 2 (timeout).
- R6: The response is read from address 0xC as four dwords in this order: header low, header high, offset, status. Each read is followed at once by a write of 0 to address 0xC.
- R7: When the response header differs from {high = 4, low = request header low}, the run ends with code 3 (bad header). This check wins over all other response checks.
- R8: An offset other than 0xFFFF_FFFF that is greater than `image_len` ends the run with code 4 (bad offset). An offset equal to `image_len` is accepted.
- R9: A response status with bit 2 set ends the run with code 5 (protocol). This check ranks below R7 and R8.
- R10: A valid response whose offset is 0xFFFF_FFFF ends the run with `done` = 1 and code 0.
- R11: After any other valid response, the next transaction fetches its chunk at the returned byte offset. The first transaction uses offset 0.
- R12: When MAX_XACT transactions have completed without reaching the end offset, the run ends with code 6 (limit).
- R13: Reset leaves the block idle, with `done`, `err_code` and `bus_req` at 0. `done` and `err_code` hold until a start pulse while idle, and a start pulse while busy has no effect.
- R14: Once raised, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay unchanged until the cycle with `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a staging run when idle |
| image_len | input | 32 | Image length in bytes, bound for returned offsets |
| src_offset | output | 32 | Byte offset of the current chunk in the image |
| src_index | output | IDXW | Dword index within the current chunk |
| src_data | input | 32 | Image dword at src_offset/src_index, same cycle |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 4 | Register byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access completes in this cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run ended at the end offset |
| err_code | output | 3 | 0 none, 1 io, 2 timeout, 3 bad header, 4 bad offset, 5 protocol, 6 limit |

## Verification
The bench builds the block with CHUNK_DW = 4, POLL_CYCLES = 4, POLL_LIMIT = 3 and MAX_XACT = 3. These small values let a full poll-timeout run finish in a few dozen cycles, and they let a run reach the transaction limit after three chunks. The defaults correspond to a 10-second budget polled every millisecond at 100 MHz, which would be out of reach in a short run. A behavioural device in the bench logs every bus access and scripts a status and response for each transaction. Each run's log is then compared field by field against the request and response layout.

// File: rtl/mbox_seq_pkg.sv
// Shared constants and types for the mailbox chunk transfer sequencer.
// Assumes a 32-bit register bus with byte addresses held in BUS_AW bits.
package mbox_seq_pkg;
    localparam int BUS_AW = 4;

    localparam logic [BUS_AW-1:0] ADDR_CTRL  = 4'h0;
    localparam logic [BUS_AW-1:0] ADDR_STAT  = 4'h4;
    localparam logic [BUS_AW-1:0] ADDR_WDATA = 4'h8;
    localparam logic [BUS_AW-1:0] ADDR_RDATA = 4'hC;

    localparam logic [31:0] CTRL_GO     = 32'h8000_0000;
    localparam logic [31:0] END_OFFSET  = 32'hFFFF_FFFF;
    localparam logic [31:0] CMD_LOAD    = 32'd3;
    localparam logic [7:0]  OBJ_STAGE   = 8'h0B;
    localparam logic [31:0] RESP_DWORDS = 32'd4;

    localparam int STAT_READY = 31;
    localparam int STAT_FAULT = 2;
    localparam int RESP_FAULT = 2;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_IO      = 3'd1,
        ERR_TIMEOUT = 3'd2,
        ERR_BAD_HDR = 3'd3,
        ERR_BAD_OFF = 3'd4,
        ERR_PROTO   = 3'd5,
        ERR_LIMIT   = 3'd6
    } err_e;
endpackage

// File: rtl/mbox_poll_timer.sv
// Poll pacing for the sequencer: counts the wait before each status read
// and the number of status reads made since the last clear.
// Assumes run is held for the whole wait and polled pulses once per read.
module mbox_poll_timer #(
    parameter int POLL_CYCLES = 100000,
    parameter int POLL_LIMIT  = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic polled,
    output logic wait_over,
    output logic last_poll
);
    localparam int ICW = $clog2(POLL_CYCLES + 1);
    localparam int ACW = $clog2(POLL_LIMIT + 1);

    logic [ICW-1:0] icnt;
    logic [ACW-1:0] acnt;

    assign wait_over = run && (icnt == ICW'(POLL_CYCLES - 1));
    assign last_poll = (acnt == ACW'(POLL_LIMIT - 1));

    // Advance the interval and attempt counters.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            icnt <= '0;
            acnt <= '0;
        end else begin
            if (run) icnt <= wait_over ? '0 : icnt + 1'b1;
            if (polled) acnt <= acnt + 1'b1;
        end
    end
endmodule

// File: rtl/mbox_resp_check.sv
// Combinational validation of a four-dword response. A header mismatch
// ranks first, then an out-of-range offset, then the status fault flag.
module mbox_resp_check
    import mbox_seq_pkg::*;
(
    input  logic [31:0] hdr_lo,
    input  logic [31:0] hdr_hi,
    input  logic [31:0] offset,
    input  logic [31:0] status,
    input  logic [31:0] image_len,
    input  logic [31:0] exp_lo,
    output err_e        verdict,
    output logic        at_end
);
    // Rank the response faults and flag the end marker.
    always_comb begin
        at_end = (offset == END_OFFSET);
        if (hdr_lo != exp_lo || hdr_hi != RESP_DWORDS)
            verdict = ERR_BAD_HDR;
        else if (!at_end && offset > image_len)
            verdict = ERR_BAD_OFF;
        else if (status[RESP_FAULT])
            verdict = ERR_PROTO;
        else
            verdict = ERR_NONE;
    end
endmodule

// File: rtl/mbox_stage_seq.sv
// Mailbox chunk transfer sequencer. Sends request objects, starts the
// device, polls status, reads and validates the response, and follows
// the returned offset until the end marker, an error or the limit.
// Assumes the image source answers combinationally and the bus holds
// each access until bus_ack.
module mbox_stage_seq
    import mbox_seq_pkg::*;
#(
    parameter int          CHUNK_DW    = 8,
    parameter logic [15:0] OWNER_ID    = 16'h1A2B,
    parameter int          POLL_CYCLES = 100000,
    parameter int          POLL_LIMIT  = 10000,
    parameter int          MAX_XACT    = 64,
    localparam int         IDXW        = (CHUNK_DW > 1) ? $clog2(CHUNK_DW) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       image_len,
    output logic [31:0]       src_offset,
    output logic [IDXW-1:0]   src_index,
    input  logic [31:0]       src_data,
    output logic              bus_req,
    output logic              bus_we,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ack,
    output logic              busy,
    output logic              done,
    output logic [2:0]        err_code
);
    localparam int          REQ_WORDS = 4 + CHUNK_DW;
    localparam int          WCW       = $clog2(REQ_WORDS);
    localparam int          XCW       = $clog2(MAX_XACT + 1);
    localparam logic [31:0] HDR_LO    = {8'h00, OBJ_STAGE, OWNER_ID};
    localparam logic [31:0] HDR_HI    = 32'(REQ_WORDS);

    typedef enum logic [2:0] {
        S_IDLE, S_WR, S_GO, S_WAIT, S_POLL, S_RD, S_RACK, S_EVAL
    } state_e;

    state_e         st;
    logic [WCW-1:0] widx;
    logic [WCW-1:0] wm4;
    logic [1:0]     ridx;
    logic [XCW-1:0] xact;
    logic [31:0]    off_q;
    logic [31:0]    r_lo, r_hi, r_off, r_stat;
    err_e           err_q;
    err_e           verdict;
    logic           at_end;
    logic           wait_over, last_poll;

    mbox_poll_timer #(
        .POLL_CYCLES(POLL_CYCLES),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (st == S_GO),
        .run      (st == S_WAIT),
        .polled   (st == S_POLL && bus_ack),
        .wait_over(wait_over),
        .last_poll(last_poll)
    );

    mbox_resp_check u_check (
        .hdr_lo   (r_lo),
        .hdr_hi   (r_hi),
        .offset   (r_off),
        .status   (r_stat),
        .image_len(image_len),
        .exp_lo   (HDR_LO),
        .verdict  (verdict),
        .at_end   (at_end)
    );

    assign wm4        = widx - WCW'(4);
    assign src_index  = wm4[IDXW-1:0];
    assign src_offset = off_q;
    assign busy       = (st != S_IDLE);
    assign err_code   = err_q;

    // Drive the bus access belonging to the current state.
    always_comb begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = ADDR_WDATA;
        bus_wdata = '0;
        case (st)
            S_WR: begin
                case (widx)
                    WCW'(0): bus_wdata = HDR_LO;
                    WCW'(1): bus_wdata = HDR_HI;
                    WCW'(2): bus_wdata = CMD_LOAD;
                    WCW'(3): bus_wdata = '0;
                    default: bus_wdata = src_data;
                endcase
            end
            S_GO:   begin bus_addr = ADDR_CTRL; bus_wdata = CTRL_GO; end
            S_POLL: begin bus_we = 1'b0; bus_addr = ADDR_STAT; end
            S_RD:   begin bus_we = 1'b0; bus_addr = ADDR_RDATA; end
            S_RACK: bus_addr = ADDR_RDATA;
            default: bus_req = 1'b0;
        endcase
    end

    // Sequence the request, start, poll, response and evaluation steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            done   <= 1'b0;
            err_q  <= ERR_NONE;
            off_q  <= '0;
            xact   <= '0;
            widx   <= '0;
            ridx   <= '0;
            r_lo   <= '0;
            r_hi   <= '0;
            r_off  <= '0;
            r_stat <= '0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    done  <= 1'b0;
                    err_q <= ERR_NONE;
                    off_q <= '0;
                    xact  <= '0;
                    widx  <= '0;
                    st    <= S_WR;
                end
                S_WR: if (bus_ack) begin
                    if (widx == WCW'(REQ_WORDS - 1)) st <= S_GO;
                    else widx <= widx + 1'b1;
                end
                S_GO: if (bus_ack) st <= S_WAIT;
                S_WAIT: if (wait_over) st <= S_POLL;
                S_POLL: if (bus_ack) begin
                    if (bus_rdata[STAT_READY] || last_poll) begin
                        if (bus_rdata[STAT_FAULT]) begin
                            err_q <= ERR_IO;
                            st    <= S_IDLE;
                        end else if (!bus_rdata[STAT_READY]) begin
                            err_q <= ERR_TIMEOUT;
                            st    <= S_IDLE;
                        end else begin
                            ridx <= '0;
                            st   <= S_RD;
                        end
                    end else begin
                        st <= S_WAIT;
                    end
                end
                S_RD: if (bus_ack) begin
                    case (ridx)
                        2'd0: r_lo   <= bus_rdata;
                        2'd1: r_hi   <= bus_rdata;
                        2'd2: r_off  <= bus_rdata;
                        default: r_stat <= bus_rdata;
                    endcase
                    st <= S_RACK;
                end
                S_RACK: if (bus_ack) begin
                    if (ridx == 2'd3) st <= S_EVAL;
                    else begin
                        ridx <= ridx + 1'b1;
                        st   <= S_RD;
                    end
                end
                S_EVAL: begin
                    if (verdict != ERR_NONE) begin
                        err_q <= verdict;
                        st    <= S_IDLE;
                    end else if (at_end) begin
                        done <= 1'b1;
                        st   <= S_IDLE;
                    end else if (xact == XCW'(MAX_XACT - 1)) begin
                        err_q <= ERR_LIMIT;
                        st    <= S_IDLE;
                    end else begin
                        off_q <= r_off;
                        xact  <= xact + 1'b1;
                        widx  <= '0;
                        st    <= S_WR;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mbox_stage_seq_chk.sv
// Protocol checker for the sequencer's bus and result ports, bound to
// every instance of the top module.
module mbox_stage_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        bus_req,
    input logic        bus_we,
    input logic [3:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        bus_ack,
    input logic        busy,
    input logic        done,
    input logic [2:0]  err_code
);
    p_req_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

    p_go_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_addr == 4'h0 |-> bus_wdata == 32'h8000_0000);

    p_read_acked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && !bus_we && bus_addr == 4'hC |=> bus_req && bus_we && bus_addr == 4'hC && bus_wdata == 32'h0);

    p_io_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && !bus_we && bus_addr == 4'h4 && bus_rdata[31] && bus_rdata[2] |=> !busy && err_code == 3'd1);

    p_done_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> err_code == 3'd0 && !busy);

    p_result_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(err_code) && $stable(done));
endmodule

bind mbox_stage_seq mbox_stage_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .bus_ack  (bus_ack),
    .busy     (busy),
    .done     (done),
    .err_code (err_code)
);

// File: tb/mbox_stage_seq_tb_top.sv
// Directed bench: a behavioural device answers the bus, logs every access
// and returns scripted status and responses per transaction.
module mbox_stage_seq_tb_top;
    localparam int          CHUNK = 4;
    localparam int          POLLC = 4;
    localparam int          POLLN = 3;
    localparam int          MAXX  = 3;
    localparam logic [15:0] OWNER = 16'h1A2B;
    localparam logic [31:0] HLO   = {8'h00, 8'h0B, OWNER};
    localparam logic [31:0] ENDO  = 32'hFFFF_FFFF;
    localparam int          XLEN  = 14 + CHUNK;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] image_len = 32'd64;
    logic [31:0] src_offset;
    logic [1:0]  src_index;
    logic [31:0] src_data;
    logic        bus_req, bus_we;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic        busy, done;
    logic [2:0]  err_code;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign src_data = (src_offset << 8) ^ (32'hA500_0000 | 32'(src_index));

    mbox_stage_seq #(
        .CHUNK_DW(CHUNK), .OWNER_ID(OWNER), .POLL_CYCLES(POLLC),
        .POLL_LIMIT(POLLN), .MAX_XACT(MAXX)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .image_len(image_len),
        .src_offset(src_offset), .src_index(src_index), .src_data(src_data),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .busy(busy), .done(done), .err_code(err_code)
    );

    // Device model state and script.
    logic        la_we   [0:255];
    logic [3:0]  la_addr [0:255];
    logic [31:0] la_data [0:255];
    int ln, n_go, poll_n, rd_idx, hold_viol;
    int cfg_ready_after;
    logic        cfg_st_err;
    logic [31:0] cfg_hdr_hi [0:7];
    logic [31:0] cfg_off    [0:7];
    logic [31:0] cfg_stat   [0:7];
    logic        pend_q;
    logic [31:0] pend_wd;
    logic [3:0]  pend_ad;
    logic        pend_we;

    function automatic logic [31:0] dev_read(input logic [3:0] a);
        int ri;
        ri = (n_go > 0) ? ((n_go - 1) % 8) : 0;
        if (a == 4'h4)
            return {(poll_n + 1 >= cfg_ready_after), 28'h0, cfg_st_err, 2'b00};
        case (rd_idx)
            0: return HLO;
            1: return cfg_hdr_hi[ri];
            2: return cfg_off[ri];
            default: return cfg_stat[ri];
        endcase
    endfunction

    // Answer each request one cycle later, log accepted accesses.
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack <= 1'b0;
            pend_q  = 1'b0;
        end else begin
            if (pend_q && (!bus_req || bus_we != pend_we || bus_addr != pend_ad || bus_wdata != pend_wd))
                hold_viol = hold_viol + 1;
            pend_q  = bus_req && !bus_ack;
            pend_we = bus_we;
            pend_ad = bus_addr;
            pend_wd = bus_wdata;
            if (bus_req && bus_ack) begin
                if (ln < 256) begin
                    la_we[ln]   = bus_we;
                    la_addr[ln] = bus_addr;
                    la_data[ln] = bus_we ? bus_wdata : bus_rdata;
                end
                ln = ln + 1;
                if (bus_we && bus_addr == 4'h0) begin n_go = n_go + 1; poll_n = 0; end
                if (!bus_we && bus_addr == 4'h4) poll_n = poll_n + 1;
                if (!bus_we && bus_addr == 4'hC) rd_idx = (rd_idx + 1) % 4;
                bus_ack <= 1'b0;
            end else if (bus_req && !bus_ack) begin
                bus_ack   <= 1'b1;
                bus_rdata <= dev_read(bus_addr);
            end else begin
                bus_ack <= 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        ln = 0; n_go = 0; poll_n = 0; rd_idx = 0;
        cfg_ready_after = 1; cfg_st_err = 1'b0;
        for (int i = 0; i < 8; i++) begin
            cfg_hdr_hi[i] = 32'd4; cfg_off[i] = ENDO; cfg_stat[i] = 32'h1;
        end
    endtask

    task automatic run_stage(input int extra_start_at);
        int n;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        n = 0;
        while (busy && n < 5000) begin
            n++;
            if (n == extra_start_at) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        if (busy) chk(1'b0, "run watchdog", 32'(n), 32'd0);
    endtask

    // Compare one transaction in the log starting at pos.
    task automatic check_xact(input int pos, input logic [31:0] off, input int nstat, input string tag);
        bit ok;
        ok = 1'b1;
        for (int i = 0; i < 4 + CHUNK; i++) begin
            logic [31:0] e;
            case (i)
                0: e = HLO;
                1: e = 32'(4 + CHUNK);
                2: e = 32'd3;
                3: e = 32'd0;
                default: e = (off << 8) ^ (32'hA500_0000 | 32'(i - 4));
            endcase
            if (!la_we[pos+i] || la_addr[pos+i] != 4'h8 || la_data[pos+i] != e) begin
                ok = 1'b0;
                chk(1'b0, {tag, " R1 R2 request dword"}, la_data[pos+i], e);
            end
        end
        if (ok) chk(1'b1, "R1", 0, 0);
        chk(la_we[pos+4+CHUNK] && la_addr[pos+4+CHUNK] == 4'h0 && la_data[pos+4+CHUNK] == 32'h8000_0000,
            {tag, " R3 start write"}, la_data[pos+4+CHUNK], 32'h8000_0000);
        ok = 1'b1;
        for (int i = 0; i < nstat; i++)
            if (la_we[pos+5+CHUNK+i] || la_addr[pos+5+CHUNK+i] != 4'h4) ok = 1'b0;
        chk(ok, {tag, " R4 status reads"}, 32'(ok), 32'd1);
        ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            int p;
            p = pos + 5 + CHUNK + nstat + i;
            if (la_addr[p] != 4'hC || la_we[p] != (i % 2 == 1) || (i % 2 == 1 && la_data[p] != 0)) ok = 1'b0;
        end
        chk(ok, {tag, " R6 response read/ack pairs"}, 32'(ok), 32'd1);
    endtask

    task automatic t_reset();
        chk(!busy && !done && err_code == 0 && !bus_req, "R13 reset state",
            {28'h0, busy, done, bus_req, 1'b0} | 32'(err_code), 32'd0);
    endtask

    task automatic t_single();
        clear_model(); cfg_ready_after = 2;
        run_stage(0);
        chk(done && err_code == 0, "R10 done at end offset", 32'(err_code), 32'd0);
        chk(ln == XLEN + 1, "R4 one extra status read before ready", 32'(ln), 32'(XLEN + 1));
        check_xact(0, 32'd0, 2, "single");
    endtask

    task automatic t_multi();
        clear_model(); cfg_off[0] = 32'd16;
        run_stage(0);
        chk(done && err_code == 0, "R10 multi done", 32'(err_code), 32'd0);
        chk(n_go == 2, "R11 two transactions", 32'(n_go), 32'd2);
        check_xact(0, 32'd0, 1, "multi0");
        check_xact(XLEN, 32'd16, 1, "multi1 R11");
    endtask

    task automatic t_io();
        clear_model(); cfg_st_err = 1'b1;
        run_stage(0);
        chk(err_code == 1 && !done, "R5 io error", 32'(err_code), 32'd1);
        chk(ln == 6 + CHUNK, "R5 no response read after io", 32'(ln), 32'(6 + CHUNK));
    endtask

    task automatic t_timeout();
        clear_model(); cfg_ready_after = 100;
        run_stage(0);
        chk(err_code == 2, "R5 timeout", 32'(err_code), 32'd2);
        chk(ln == 5 + CHUNK + POLLN, "R4 poll limit reads", 32'(ln), 32'(5 + CHUNK + POLLN));
    endtask

    task automatic t_badhdr();
        clear_model(); cfg_hdr_hi[0] = 32'd8; cfg_off[0] = 32'd1000; cfg_stat[0] = 32'h4;
        run_stage(0);
        chk(err_code == 3, "R7 bad header wins", 32'(err_code), 32'd3);
    endtask

    task automatic t_badoff();
        clear_model(); cfg_off[0] = 32'd65; cfg_stat[0] = 32'h4;
        run_stage(0);
        chk(err_code == 4, "R8 offset past length", 32'(err_code), 32'd4);
        clear_model(); cfg_off[0] = 32'd64;
        run_stage(0);
        chk(done && err_code == 0, "R8 offset equal to length accepted", 32'(err_code), 32'd0);
        chk(la_data[XLEN+4] == ((32'd64 << 8) ^ 32'hA500_0000), "R8 R11 chunk at offset 64",
            la_data[XLEN+4], (32'd64 << 8) ^ 32'hA500_0000);
    endtask

    task automatic t_proto();
        clear_model(); cfg_stat[0] = 32'h4;
        run_stage(0);
        chk(err_code == 5 && !done, "R9 protocol error", 32'(err_code), 32'd5);
    endtask

    task automatic t_limit_hold();
        clear_model(); cfg_off[0] = 32'd0; cfg_off[1] = 32'd8; cfg_off[2] = 32'd0;
        run_stage(0);
        chk(err_code == 6, "R12 transaction limit", 32'(err_code), 32'd6);
        chk(n_go == MAXX, "R12 transactions sent", 32'(n_go), 32'(MAXX));
        repeat (30) @(negedge clk);
        chk(err_code == 6 && !done && ln == MAXX * XLEN, "R13 result held", 32'(err_code), 32'd6);
    endtask

    task automatic t_ignore_start();
        clear_model(); cfg_off[0] = 32'd16;
        run_stage(6);
        chk(done && err_code == 0, "R13 start while busy ignored", 32'(err_code), 32'd0);
        chk(ln == 2 * XLEN && n_go == 2, "R13 no restart", 32'(ln), 32'(2 * XLEN));
        chk(hold_viol == 0, "R14 request held until ack", 32'(hold_viol), 32'd0);
    endtask

    bit finished = 1'b0;

    initial begin
        hold_viol = 0;
        clear_model();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_io();
        t_timeout();
        t_badhdr();
        t_badoff();
        t_proto();
        t_limit_hold();
        t_ignore_start();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule